// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This execution-stage unit decides whether a fixed-point trap instruction must raise a trap. It receives a register value, a second register value, a 16-bit signed immediate, a five-bit condition mask and two mode flags. One flag selects word or doubleword operation. The other makes the sign-extended immediate stand in for the second register. From these inputs the unit forms two full-width comparands. It evaluates signed less/greater, equality, and unsigned less/greater between them. It then requests a trap when at least one relation that the mask enables is true.

The outcome passes through a single registered stage with a valid/ready handshake. The consumer receives one trap flag and the vector of conditions that were both enabled and true. The unit changes no other state. Decode, the exception path, the program counter and the register file are all outside the block.

Top module: `trap_eval_unit`

## Requirements
- R1: The mask enables one relation per bit: `cond_mask[4]` signed less-than, `cond_mask[3]` signed greater-than, `cond_mask[2]` equality, `cond_mask[1]` unsigned less-than, `cond_mask[0]` unsigned greater-than. Each bit of `cond_hits` is the same relation at the same bit position, ANDed with its mask bit.
- R2: `trap_req` is 1 exactly when `cond_hits` has at least one bit set.
- R3: With `word_mode` = 0 and `use_imm` = 0, both register operands are compared at their full DATA_W width, with no extension or truncation.
- R4: With `word_mode` = 1, only the low DATA_W/2 bits of each register operand are used. Each is sign-extended to DATA_W before every relation, the unsigned ones included. The upper halves have no effect.
- R5: With `use_imm` = 1, `imm` sign-extended to DATA_W replaces `src_b`, in both modes, and `src_b` has no effect. In word mode `src_a` still gets the word-mode extension.
- R6: A mask of all zeros never traps. A mask of all ones always traps.
- R7: An input is accepted when `in_valid` and `in_ready` are both 1. Its result appears with `out_valid` = 1 on the following clock. `in_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `trap_req` and `cond_hits` hold their values and new inputs are not taken.
- R9: A synchronous active-low reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operands and controls are valid |
| in_ready | output | 1 | Unit can accept an input this cycle |
| src_a | input | DATA_W | First register operand |
| src_b | input | DATA_W | Second register operand |
| imm | input | IMM_W | Signed immediate |
| cond_mask | input | 5 | Relation enable mask (see R1) |
| word_mode | input | 1 | 1 = word compare, 0 = doubleword compare |
| use_imm | input | 1 | 1 = immediate replaces second operand |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer accepts the result |
| trap_req | output | 1 | Trap requested |
| cond_hits | output | 5 | Enabled relations that hold |

## Verification
The hardest case to reach is where word-mode sign extension changes an unsigned result. Purely random operands seldom have a low half with its sign bit set while the upper half contradicts it, and the other operand is rarely close by. Directed transactions therefore place 0x80000000 against 0x7FFFFFFF, with unrelated upper halves. They also send operands whose low halves are equal but whose upper halves differ, through both modes. Random traffic biases the second operand toward a copy of the first so that equality hits occur. It also throttles `out_ready` so that held results meet new requests.

// File: rtl/trap_eval_pkg.sv
// Package: shared bit positions of the relation vector.
// Assumes the five-bit mask and hit vector share one ordering.
package trap_eval_pkg;
    localparam int COND_W  = 5;
    localparam int IDX_SLT = 4;
    localparam int IDX_SGT = 3;
    localparam int IDX_EQ  = 2;
    localparam int IDX_ULT = 1;
    localparam int IDX_UGT = 0;
endpackage

// File: rtl/trap_operand_former.sv
// Forms the two full-width comparands from register operands and immediate.
// Assumes DATA_W is even and IMM_W <= DATA_W.
module trap_operand_former #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              word_mode,
    input  logic              use_imm,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_word_ext;
    logic [DATA_W-1:0] b_word_ext;
    logic [DATA_W-1:0] imm_ext;

    // Sign-extend the low halves and the immediate to full width.
    always_comb begin
        a_word_ext = {{(DATA_W-HALF_W){src_a[HALF_W-1]}}, src_a[HALF_W-1:0]};
        b_word_ext = {{(DATA_W-HALF_W){src_b[HALF_W-1]}}, src_b[HALF_W-1:0]};
        imm_ext    = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end

    // Pick comparands by mode: immediate wins over the second register.
    always_comb begin
        opa = word_mode ? a_word_ext : src_a;
        if (use_imm)
            opb = imm_ext;
        else
            opb = word_mode ? b_word_ext : src_b;
    end
endmodule

// File: rtl/trap_relation_cmp.sv
// Evaluates signed, unsigned and equality relations and masks them.
// Assumes both comparands are already full width; clk/rst_n feed checks only.
module trap_relation_cmp
    import trap_eval_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [COND_W-1:0] cond_mask,
    output logic [COND_W-1:0] hits
);
    logic s_lt, s_gt, eq, u_lt, u_gt;
    logic [COND_W-1:0] rel;

    // Raw relations between the comparands.
    always_comb begin
        s_lt = $signed(opa) < $signed(opb);
        s_gt = $signed(opa) > $signed(opb);
        eq   = (opa == opb);
        u_lt = opa < opb;
        u_gt = opa > opb;
    end

    // Place relations at their mask positions and apply the mask.
    always_comb begin
        rel          = '0;
        rel[IDX_SLT] = s_lt;
        rel[IDX_SGT] = s_gt;
        rel[IDX_EQ]  = eq;
        rel[IDX_ULT] = u_lt;
        rel[IDX_UGT] = u_gt;
        hits         = rel & cond_mask;
    end

    // R6
    signed_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({s_lt, s_gt, eq}) == 1);
    // R6
    unsigned_trichotomy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({u_lt, u_gt, eq}) == 1);
endmodule

// File: rtl/trap_result_stage.sv
// Registered valid/ready output stage holding trap flag and hit vector.
// Assumes synchronous active-low reset; a result is held until taken.
module trap_result_stage
    import trap_eval_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COND_W-1:0] hits_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              trap_req,
    output logic [COND_W-1:0] cond_hits
);
    logic in_fire;

    // Accept when empty or when the held result leaves this cycle.
    always_comb begin
        in_ready = !out_valid || out_ready;
        in_fire  = in_valid && in_ready;
    end

    // Capture a result on accept, drop valid once consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            trap_req  <= 1'b0;
            cond_hits <= '0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            trap_req  <= |hits_in;
            cond_hits <= hits_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R7
    accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(trap_req) && $stable(cond_hits)));
endmodule

// File: rtl/trap_eval_unit.sv
// Top: conditional trap evaluation with one registered handshake stage.
// Assumes the caller holds inputs stable while in_valid waits on in_ready.
module trap_eval_unit
    import trap_eval_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [COND_W-1:0] cond_mask,
    input  logic              word_mode,
    input  logic              use_imm,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              trap_req,
    output logic [COND_W-1:0] cond_hits
);
    logic [DATA_W-1:0] opa, opb;
    logic [COND_W-1:0] hits;

    trap_operand_former #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_former (
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .word_mode(word_mode), .use_imm(use_imm),
        .opa(opa), .opb(opb)
    );

    trap_relation_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb),
        .cond_mask(cond_mask), .hits(hits)
    );

    trap_result_stage u_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .hits_in(hits), .out_valid(out_valid), .out_ready(out_ready),
        .trap_req(trap_req), .cond_hits(cond_hits)
    );

    // R1
    hits_within_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ((cond_hits & ~$past(cond_mask)) == '0));
    // R2
    trap_matches_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (trap_req == (cond_hits != '0)));
endmodule

// File: tb/trap_eval_unit_bench.sv
module trap_eval_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, out_ready, word_mode, use_imm;
    logic        in_ready, out_valid, trap_req;
    logic [63:0] src_a, src_b;
    logic [15:0] imm;
    logic [4:0]  cond_mask, cond_hits;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    bit       mv = 0;
    bit [4:0] mh = '0;

    always #2 clk = ~clk;

    trap_eval_unit u_trap_eval_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .imm(imm), .cond_mask(cond_mask),
        .word_mode(word_mode), .use_imm(use_imm), .out_valid(out_valid),
        .out_ready(out_ready), .trap_req(trap_req), .cond_hits(cond_hits)
    );

    function automatic bit [4:0] ref_hits(input logic [63:0] a, input logic [63:0] b,
                                          input logic [15:0] im, input logic [4:0] m,
                                          input logic wm, input logic ui);
        longint sa, sb;
        longint unsigned ua, ub;
        sa = wm ? longint'($signed(a[31:0])) : longint'(a);
        if (ui)      sb = longint'($signed(im));
        else if (wm) sb = longint'($signed(b[31:0]));
        else         sb = longint'(b);
        ua = sa;
        ub = sb;
        return {sa < sb, sa > sb, sa == sb, ua < ub, ua > ub} & m;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock: check in_ready, advance the model, compare outputs at negedge.
    task automatic cycle(input string tag);
        bit       rdy;
        bit [4:0] r;
        #1;
        rdy = !mv || out_ready;
        if (rst_n) chk(in_ready === rdy, tag, "in_ready", 64'(in_ready), 64'(rdy));
        r = ref_hits(src_a, src_b, imm, cond_mask, word_mode, use_imm);
        if (!rst_n) mv = 0;
        else if (in_valid && rdy) begin mv = 1; mh = r; end
        else if (out_ready) mv = 0;
        @(negedge clk);
        chk(out_valid === mv, tag, "out_valid", 64'(out_valid), 64'(mv));
        if (mv) begin
            chk(cond_hits === mh, tag, "cond_hits", 64'(cond_hits), 64'(mh));
            chk(trap_req === (|mh), tag, "trap_req", 64'(trap_req), 64'(|mh));
        end
    endtask

    // Single transaction with a hand-computed expectation.
    task automatic direct(input logic [63:0] a, input logic [63:0] b, input logic [15:0] im,
                          input logic [4:0] m, input logic wm, input logic ui,
                          input bit exp_t, input bit [4:0] exp_h, input string tag);
        src_a = a; src_b = b; imm = im; cond_mask = m; word_mode = wm; use_imm = ui;
        in_valid = 1; out_ready = 1;
        cycle(tag);
        chk(trap_req === exp_t, tag, "direct trap_req", 64'(trap_req), 64'(exp_t));
        chk(cond_hits === exp_h, tag, "direct cond_hits", 64'(cond_hits), 64'(exp_h));
        in_valid = 0;
        cycle(tag);
    endtask

    initial begin
        rst_n = 0; in_valid = 0; out_ready = 0; word_mode = 0; use_imm = 0;
        src_a = '0; src_b = '0; imm = '0; cond_mask = '0;
        @(negedge clk);
        cycle("R9"); cycle("R9");
        rst_n = 1;
        cycle("R9");
        chk(out_valid === 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);

        // R1 / R3 doubleword
        direct(64'd5, 64'd7, 16'h0, 5'b10000, 0, 0, 1, 5'b10000, "R1");
        direct(64'd5, 64'd7, 16'h0, 5'b01000, 0, 0, 0, 5'b00000, "R1");
        direct(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 16'h0, 5'b00100, 0, 0, 1, 5'b00100, "R1");
        direct(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 5'b00001, 0, 0, 1, 5'b00001, "R3");
        direct(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 5'b10000, 0, 0, 1, 5'b10000, "R3");
        direct(64'h1111_1111_0000_0042, 64'h2222_2222_0000_0042, 16'h0, 5'b00100, 0, 0, 0, 5'b00000, "R3");
        // R4 word
        direct(64'h1111_1111_0000_0042, 64'h2222_2222_0000_0042, 16'h0, 5'b00100, 1, 0, 1, 5'b00100, "R4");
        direct(64'h1234_5678_8000_0000, 64'hABCD_EF01_7FFF_FFFF, 16'h0, 5'b00001, 1, 0, 1, 5'b00001, "R4");
        direct(64'h1234_5678_8000_0000, 64'hABCD_EF01_7FFF_FFFF, 16'h0, 5'b10010, 1, 0, 1, 5'b10000, "R4");
        // R5 immediate
        direct(64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 16'hFFFD, 5'b00100, 0, 1, 1, 5'b00100, "R5");
        direct(64'd0, 64'd0, 16'h8000, 5'b01010, 0, 1, 1, 5'b01010, "R5");
        direct(64'h0000_0000_FFFF_FFFF, 64'd5, 16'hFFFF, 5'b00100, 1, 1, 1, 5'b00100, "R5");
        // R6 masks
        direct(64'd9, 64'd9, 16'h0, 5'b00000, 0, 0, 0, 5'b00000, "R6");
        direct(64'd9, 64'd9, 16'h0, 5'b11111, 0, 0, 1, 5'b00100, "R6");
        for (int i = 0; i < 40; i++) begin
            src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom}; imm = 16'($urandom);
            cond_mask = 5'b11111; word_mode = 1'($urandom); use_imm = 1'($urandom);
            in_valid = 1; out_ready = 1;
            cycle("R6");
            chk(trap_req === 1'b1, "R6", "all-ones mask trap", 64'(trap_req), 64'd1);
        end

        // R8 hold under back-pressure
        src_a = 64'd3; src_b = 64'd4; cond_mask = 5'b10000; word_mode = 0; use_imm = 0;
        in_valid = 1; out_ready = 0;
        cycle("R7");
        src_a = 64'd8;
        for (int i = 0; i < 4; i++) begin
            cycle("R8");
            chk(trap_req === 1'b1, "R8", "held trap_req", 64'(trap_req), 64'd1);
        end
        out_ready = 1;
        cycle("R8");
        chk(trap_req === 1'b0, "R8", "next result", 64'(trap_req), 64'd0);

        // R9 reset while a result is held
        out_ready = 0; in_valid = 1;
        cycle("R9");
        rst_n = 0; in_valid = 0;
        cycle("R9");
        chk(out_valid === 1'b0, "R9", "reset clears valid", 64'(out_valid), 64'd0);
        rst_n = 1;
        cycle("R9");

        // R7 random traffic with throttled consumer
        for (int i = 0; i < 3000; i++) begin
            if (!(in_valid && !in_ready)) begin
                src_a = {$urandom, $urandom};
                src_b = ($urandom % 3 == 0) ? src_a : {$urandom, $urandom};
                if ($urandom % 4 == 0) src_b[63:32] = $urandom;
                imm = 16'($urandom); cond_mask = 5'($urandom);
                word_mode = 1'($urandom); use_imm = ($urandom % 4 == 0);
                in_valid = 1'($urandom);
            end
            out_ready = ($urandom % 3 != 0);
            cycle("R7");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule